// File: doc/BRIEF.md
# Traffic-Sensitive Output Port Selector

This block sits in the routing stage of a five-port mesh router, next to the arbiter. The routing function offers up to two productive output ports for a packet: one that moves it along X and one that moves it along Y. The selector picks one of them. A two-bit configuration input chooses the selection policy:

- a fixed preference for the X move,
- the port used the fewest times,
- the port that has gone unused the longest,
- the port with the most downstream buffer credit.

For every output port the block keeps three counters: a use count, an idle age and a credit balance. Three per-port strobes drive them. The port-used strobe marks a port that was just granted. The flit-sent strobe marks a flit leaving on the port. The credit-return strobe marks a buffer slot freed downstream. The choice is a combinational function of the offered candidates and the registered counters. A strobe therefore affects the selection from the clock edge that captures it.

Port codes are 0 for the local port, 1 for +X, 2 for −X, 3 for +Y and 4 for −Y. Policy codes are 0 for the fixed X preference, 1 for fewest uses, 2 for longest idle and 3 for most credit.

Top module: `path_selector`

## Requirements
- R1: Reset clears every use count and idle age to zero and loads every credit balance with CRED_INIT (20 by default). Right after reset, two candidates under any policy resolve to the X candidate.
- R2: Under policy 0, when the X candidate is present it is selected, whatever the counter state.
- R3: When exactly one candidate is present, that candidate is selected under policies 0, 1 and 2. When no candidate is present, sel_vld_o is low.
- R4: Under policy 1, the candidate whose port has the smaller use count is selected. A port's use count rises by one on each cycle its used_i bit is high. Equal counts select the X candidate.
- R5: A use count stops at its all-ones value (255 by default) and does not wrap.
- R6: Under policy 2, the candidate whose port has the larger idle age is selected. The age clears to zero on a cycle with used_i high and otherwise rises by one each cycle. Equal ages select the X candidate.
- R7: An idle age stops at its all-ones value (255 by default) and does not wrap.
- R8: Under policy 3, the candidate whose port has the larger credit balance is selected, and equal balances select the X candidate. A balance drops by one on a cycle with only sent_i high and rises by one on a cycle with only cred_ret_i high. It stays at zero and at its all-ones value.
- R9: Under policy 3, a port with zero credit is never selected. If neither candidate has credit, sel_vld_o is low.
- R10: A cycle with both sent_i and cred_ret_i high for a port leaves its balance unchanged.
- R11: A candidate whose port code is 5 or above is treated as absent. Code 0, the local port, is a legal candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_i | input | 2 | Selection policy code (0 fixed, 1 fewest uses, 2 longest idle, 3 most credit) |
| x_vld_i | input | 1 | X-dimension candidate present |
| x_port_i | input | 3 | X-dimension candidate port code |
| y_vld_i | input | 1 | Y-dimension candidate present |
| y_port_i | input | 3 | Y-dimension candidate port code |
| used_i | input | 5 | Per-port granted strobe, bit n is port n |
| sent_i | input | 5 | Per-port flit-sent strobe |
| cred_ret_i | input | 5 | Per-port credit-return strobe |
| sel_vld_o | output | 1 | A port was selected |
| sel_port_o | output | 3 | Selected port code |

## Verification
The assertions take the counter strobes as independent per-port pulses. They also assume the candidate inputs are steady for the whole cycle in which they are sampled. They do not require the two candidates to differ, and they do not require a strobed port to have been offered. The stimulus changes candidates and strobes only on the falling edge. It holds each strobe for a whole number of cycles and stays below the point where a credit balance would exceed its maximum. Saturation is reached by holding a strobe, or by waiting long enough that a wrapping counter would give a different choice.

// File: rtl/psel_pkg.sv
package psel_pkg;
    localparam int NPORT = 5;
    localparam int PW    = 3;

    typedef enum logic [1:0] {
        POL_STATIC = 2'd0,
        POL_LFU    = 2'd1,
        POL_LRU    = 2'd2,
        POL_CREDIT = 2'd3
    } pol_e;

    typedef logic [PW-1:0] port_t;
endpackage

// File: rtl/psel_port_ctr.sv
module psel_port_ctr #(
    parameter int UW        = 8,
    parameter int AW        = 8,
    parameter int CW        = 5,
    parameter int CRED_INIT = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          used_i,
    input  logic          sent_i,
    input  logic          ret_i,
    output logic [UW-1:0] use_o,
    output logic [AW-1:0] age_o,
    output logic [CW-1:0] cred_o
);
    localparam logic [UW-1:0] USE_MAX  = '1;
    localparam logic [AW-1:0] AGE_MAX  = '1;
    localparam logic [CW-1:0] CRED_MAX = '1;
    localparam logic [CW-1:0] CRED_RST = CW'(CRED_INIT);

    typedef struct packed {
        logic [UW-1:0] use_cnt;
        logic [AW-1:0] age;
        logic [CW-1:0] cred;
    } ctr_t;

    ctr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (used_i && st_q.use_cnt != USE_MAX)
            st_d.use_cnt = st_q.use_cnt + UW'(1);
        if (used_i)
            st_d.age = '0;
        else if (st_q.age != AGE_MAX)
            st_d.age = st_q.age + AW'(1);
        if (sent_i && !ret_i && st_q.cred != '0)
            st_d.cred = st_q.cred - CW'(1);
        else if (ret_i && !sent_i && st_q.cred != CRED_MAX)
            st_d.cred = st_q.cred + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.use_cnt <= '0;
            st_q.age     <= '0;
            st_q.cred    <= CRED_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign use_o  = st_q.use_cnt;
    assign age_o  = st_q.age;
    assign cred_o = st_q.cred;

    // R5: a full use count stays full
    a_r5_use_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (use_o == USE_MAX) |=> (use_o == USE_MAX));

    // R6: a granted port restarts its idle age
    a_r6_age_clear: assert property (@(posedge clk) disable iff (!rst_n)
        used_i |=> (age_o == '0));

    // R7: a full age either holds or clears, never wraps
    a_r7_age_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (age_o == AGE_MAX && !used_i) |=> (age_o == AGE_MAX));

    // R8: a lone send takes exactly one credit
    a_r8_cred_dec: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_i && !ret_i && cred_o != '0) |=> (cred_o == $past(cred_o) - CW'(1)));

    // R10: send and return together cancel
    a_r10_cred_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sent_i && ret_i) |=> $stable(cred_o));
endmodule

// File: rtl/psel_choose.sv
module psel_choose
    import psel_pkg::*;
#(
    parameter int UW = 8,
    parameter int AW = 8,
    parameter int CW = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                policy_i,
    input  logic                      x_vld_i,
    input  port_t                     x_port_i,
    input  logic                      y_vld_i,
    input  port_t                     y_port_i,
    input  logic [NPORT-1:0][UW-1:0]  use_i,
    input  logic [NPORT-1:0][AW-1:0]  age_i,
    input  logic [NPORT-1:0][CW-1:0]  cred_i,
    output logic                      sel_vld_o,
    output port_t                     sel_port_o
);
    pol_e          pol;
    logic          x_in, y_in, x_ok, y_ok, take_y;
    logic [UW-1:0] xu, yu;
    logic [AW-1:0] xa, ya;
    logic [CW-1:0] xc, yc;

    assign pol  = pol_e'(policy_i);
    assign x_in = x_vld_i && (x_port_i < port_t'(NPORT));
    assign y_in = y_vld_i && (y_port_i < port_t'(NPORT));

    always_comb begin
        xu = '0; xa = '0; xc = '0;
        yu = '0; ya = '0; yc = '0;
        for (int p = 0; p < NPORT; p++) begin
            if (x_port_i == port_t'(p)) begin
                xu = use_i[p]; xa = age_i[p]; xc = cred_i[p];
            end
            if (y_port_i == port_t'(p)) begin
                yu = use_i[p]; ya = age_i[p]; yc = cred_i[p];
            end
        end
    end

    always_comb begin
        x_ok = x_in && (pol != POL_CREDIT || xc != '0);
        y_ok = y_in && (pol != POL_CREDIT || yc != '0);
        unique case (pol)
            POL_STATIC: take_y = 1'b0;
            POL_LFU:    take_y = (yu < xu);
            POL_LRU:    take_y = (ya > xa);
            POL_CREDIT: take_y = (yc > xc);
            default:    take_y = 1'b0;
        endcase
        sel_vld_o  = x_ok || y_ok;
        sel_port_o = '0;
        if (x_ok && y_ok)
            sel_port_o = take_y ? y_port_i : x_port_i;
        else if (x_ok)
            sel_port_o = x_port_i;
        else if (y_ok)
            sel_port_o = y_port_i;
    end

    logic [CW-1:0] chk_cred;
    always_comb begin
        chk_cred = '0;
        for (int p = 0; p < NPORT; p++)
            if (sel_port_o == port_t'(p)) chk_cred = cred_i[p];
    end

    // R2: fixed policy keeps the X move
    a_r2_static_x: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd0 && x_vld_i && x_port_i < port_t'(NPORT))
            |-> (sel_vld_o && sel_port_o == x_port_i));

    // R3: nothing offered, nothing chosen
    a_r3_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!x_vld_i && !y_vld_i) |-> !sel_vld_o);

    // R9: credit policy never lands on an empty port
    a_r9_no_empty_port: assert property (@(posedge clk) disable iff (!rst_n)
        (policy_i == 2'd3 && sel_vld_o) |-> (chk_cred != '0));

    // R11: result is always a real port and one of the offers
    a_r11_legal_port: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vld_o |-> (sel_port_o < port_t'(NPORT)
                       && ((x_vld_i && sel_port_o == x_port_i)
                           || (y_vld_i && sel_port_o == y_port_i))));
endmodule

// File: rtl/path_selector.sv
module path_selector
    import psel_pkg::*;
#(
    parameter int UW        = 8,
    parameter int AW        = 8,
    parameter int CW        = 5,
    parameter int CRED_INIT = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_i,
    input  logic             x_vld_i,
    input  logic [PW-1:0]    x_port_i,
    input  logic             y_vld_i,
    input  logic [PW-1:0]    y_port_i,
    input  logic [NPORT-1:0] used_i,
    input  logic [NPORT-1:0] sent_i,
    input  logic [NPORT-1:0] cred_ret_i,
    output logic             sel_vld_o,
    output logic [PW-1:0]    sel_port_o
);
    logic [NPORT-1:0][UW-1:0] use_cnt;
    logic [NPORT-1:0][AW-1:0] age_cnt;
    logic [NPORT-1:0][CW-1:0] cred_cnt;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        psel_port_ctr #(
            .UW(UW), .AW(AW), .CW(CW), .CRED_INIT(CRED_INIT)
        ) u_ctr (
            .clk    (clk),
            .rst_n  (rst_n),
            .used_i (used_i[p]),
            .sent_i (sent_i[p]),
            .ret_i  (cred_ret_i[p]),
            .use_o  (use_cnt[p]),
            .age_o  (age_cnt[p]),
            .cred_o (cred_cnt[p])
        );
    end

    psel_choose #(.UW(UW), .AW(AW), .CW(CW)) u_choose (
        .clk        (clk),
        .rst_n      (rst_n),
        .policy_i   (policy_i),
        .x_vld_i    (x_vld_i),
        .x_port_i   (x_port_i),
        .y_vld_i    (y_vld_i),
        .y_port_i   (y_port_i),
        .use_i      (use_cnt),
        .age_i      (age_cnt),
        .cred_i     (cred_cnt),
        .sel_vld_o  (sel_vld_o),
        .sel_port_o (sel_port_o)
    );
endmodule

// File: tb/tb_path_selector.sv
module tb_path_selector;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] policy = 2'd0;
    logic       xv = 1'b0, yv = 1'b0;
    logic [2:0] xp = 3'd0, yp = 3'd0;
    logic [4:0] used = '0, sent = '0, ret = '0;
    logic       sel_vld;
    logic [2:0] sel_port;
    int         nchk = 0;
    int         nfail = 0;

    always #10 clk = ~clk;

    path_selector dut (
        .clk(clk), .rst_n(rst_n), .policy_i(policy),
        .x_vld_i(xv), .x_port_i(xp), .y_vld_i(yv), .y_port_i(yp),
        .used_i(used), .sent_i(sent), .cred_ret_i(ret),
        .sel_vld_o(sel_vld), .sel_port_o(sel_port)
    );

    // {policy, xv, xp, yv, yp, exp_vld, exp_port}, all taken at reset state
    localparam logic [13:0] VEC [11] = '{
        {2'd0, 1'b1, 3'd1, 1'b1, 3'd3, 1'b1, 3'd1},  // R2
        {2'd0, 1'b1, 3'd2, 1'b1, 3'd4, 1'b1, 3'd2},  // R2
        {2'd0, 1'b0, 3'd0, 1'b1, 3'd4, 1'b1, 3'd4},  // R3
        {2'd1, 1'b1, 3'd2, 1'b0, 3'd0, 1'b1, 3'd2},  // R3
        {2'd2, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0},  // R3
        {2'd3, 1'b1, 3'd1, 1'b1, 3'd4, 1'b1, 3'd1},  // R1
        {2'd1, 1'b1, 3'd1, 1'b1, 3'd3, 1'b1, 3'd1},  // R1 R4
        {2'd2, 1'b1, 3'd2, 1'b1, 3'd3, 1'b1, 3'd2},  // R1 R6
        {2'd0, 1'b1, 3'd6, 1'b1, 3'd3, 1'b1, 3'd3},  // R11
        {2'd3, 1'b1, 3'd1, 1'b1, 3'd7, 1'b1, 3'd1},  // R11
        {2'd0, 1'b1, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0}   // R11
    };

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; used = '0; sent = '0; ret = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic strobe(input logic [4:0] u, input logic [4:0] s,
                          input logic [4:0] r, input int n);
        @(negedge clk);
        used = u; sent = s; ret = r;
        repeat (n) @(negedge clk);
        used = '0; sent = '0; ret = '0;
    endtask

    task automatic check(input logic [1:0] pol, input logic cxv, input logic [2:0] cxp,
                         input logic cyv, input logic [2:0] cyp,
                         input logic ev, input logic [2:0] ep, input string tag);
        @(negedge clk);
        policy = pol; xv = cxv; xp = cxp; yv = cyv; yp = cyp;
        #5;
        nchk++;
        if (sel_vld !== ev || (ev && sel_port !== ep)) begin
            nfail++;
            $display("FAIL %s: got vld=%0b port=%0d, expected vld=%0b port=%0d",
                     tag, sel_vld, sel_port, ev, ep);
        end
    endtask

    initial begin
        #(20 * 200000);
        nfail++;
        nchk++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        do_reset();
        // table walk at reset state: R1 R2 R3 R11
        for (int i = 0; i < 11; i++) begin
            check(VEC[i][13:12], VEC[i][11], VEC[i][10:8], VEC[i][7], VEC[i][6:4],
                  VEC[i][3], VEC[i][2:0], $sformatf("R1/R2/R3/R11 vector %0d", i));
        end

        // R4 fewest uses and R6 idle age
        do_reset();
        strobe(5'b00010, '0, '0, 1);               // port 1 used once
        check(2'd1, 1, 3'd1, 1, 3'd3, 1, 3'd3, "R4 fewer uses wins");
        check(2'd2, 1, 3'd1, 1, 3'd3, 1, 3'd3, "R6 older port wins");
        strobe(5'b01000, '0, '0, 2);               // port 3 used twice
        check(2'd1, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R4 fewer uses wins after swap");
        check(2'd2, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R6 reset on use");
        check(2'd2, 1, 3'd2, 1, 3'd4, 1, 3'd2, "R6 equal ages take X");
        check(2'd0, 1, 3'd3, 1, 3'd1, 1, 3'd3, "R2 fixed ignores history");

        // R5 use count saturation
        do_reset();
        strobe(5'b00010, '0, '0, 300);
        strobe(5'b01000, '0, '0, 100);
        check(2'd1, 1, 3'd1, 1, 3'd3, 1, 3'd3, "R5 use count held at max");

        // R7 age saturation
        do_reset();
        strobe(5'b10000, '0, '0, 1);               // port 4 first
        repeat (10) @(negedge clk);
        strobe(5'b00100, '0, '0, 1);               // port 2 later
        check(2'd2, 1, 3'd2, 1, 3'd4, 1, 3'd4, "R6 longer idle wins");
        repeat (300) @(negedge clk);
        check(2'd2, 1, 3'd2, 1, 3'd4, 1, 3'd2, "R7 both ages saturated, tie to X");

        // R8 R9 R10 credit
        do_reset();
        strobe('0, 5'b00010, '0, 3);
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd3, "R8 more credit wins");
        strobe('0, '0, 5'b00010, 3);
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R8 restored, tie to X");
        strobe('0, 5'b01000, 5'b01000, 5);
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R10 send with return holds");
        strobe('0, '0, 5'b00010, 1);
        strobe('0, 5'b00010, '0, 1);
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R8 up then down nets to tie");
        strobe('0, 5'b00010, '0, 20);
        check(2'd3, 1, 3'd1, 0, 3'd0, 0, 3'd0, "R9 lone empty port refused");
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd3, "R9 empty X skipped");
        check(2'd1, 1, 3'd1, 0, 3'd0, 1, 3'd1, "R3 single offer outside credit policy");
        strobe('0, 5'b01000, '0, 20);
        check(2'd3, 1, 3'd1, 1, 3'd3, 0, 3'd0, "R9 both empty");
        strobe('0, 5'b00010, '0, 1);
        strobe('0, '0, 5'b00010, 1);
        check(2'd3, 1, 3'd1, 1, 3'd3, 1, 3'd1, "R8 zero floor then one credit");

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule